// File: doc/BRIEF.md
# Self-Reconfiguring Cell Array Tile

A square array of identical logic cells whose function is changed by a serial configuration stream rather than by a processor. Each cell drives three lanes on each of its four sides: an application value, a configuration clock or completion line, and a configuration data line. A cell reads the lanes that its neighbours drive on the facing side. Along the array border it reads the edge ports instead. There are no cell addresses. Every cell holds a pointer to its owner, and bits entering at the single seed port travel down this ownership tree. A cell fills its open children first, in a fixed side priority, and then takes seven bits for itself. A commit pulse then makes every newly shifted body live in the same cycle.

Application cells compute constant-0, constant-1, a wire from one side, or a 2:1 multiplexer with a selectable orientation. Values advance only on a global compute strobe, so configuration traffic and computation never interleave. After reset, cells outside the configurable region act as full leaves, and their bodies never change.

Top module: `reconf_tile`

## Requirements
- R1: After reset every edge application output is 0 and `seed_done_o` is 0; application outputs stay 0 until the first `step_i`.
- R2: Cell application values, and so every edge output, change only in a cycle that follows a high `step_i`.
- R3: A cell forwards each incoming bit to a non-full child before keeping bits itself, trying sides in the order left, top, right, bottom. The stream therefore fills the tree in postorder, and each body is sent most significant bit first.
- R4: A cell reports full to its owner only after it has received its own 7 bits and all of its children report full. `seed_done_o` is the seed cell's full report, and it stays high until reset.
- R5: Shifted bodies have no effect until `commit_i`. Before the commit, unconfigured cells output 0. The commit applies every pending body at once.
- R6: The body is 7 bits: [6:5] owner side (0 left, 1 top, 2 right, 3 bottom), [4:3] orientation o, [2:0] mode. Mode 000 gives constant 0, mode 001 gives constant 1, and mode 010 copies side o.
- R7: Mode 011 is a multiplexer. The select is side o; a select of 0 passes side o+1 and a select of 1 passes side o+2, both taken modulo 4.
- R8: Streaming bits into a tree whose cells are already full, and then committing, leaves every live body unchanged.
- R9: In the default reset image, cells (0,0) and (1,0) are unconfigured. (0,0) is owned by the seed port on the left edge, and (1,0) is owned from its top. Every other cell is a full leaf owned from its left, and it is constant-1 in odd columns and constant-0 in even columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_i | input | 1 | Compute strobe for application values |
| commit_i | input | 1 | Commit pulse for pending bodies |
| seed_clk_i | input | 1 | Seed configuration clock; a bit is taken on each rising edge |
| seed_dat_i | input | 1 | Seed configuration data |
| seed_done_o | output | 1 | Seed cell full report |
| west_i | input | N | Left edge application inputs, one per row |
| north_i | input | N | Top edge application inputs, one per column |
| east_i | input | N | Right edge application inputs, one per row |
| south_i | input | N | Bottom edge application inputs, one per column |
| west_o | output | N | Left edge application outputs, one per row |
| north_o | output | N | Top edge application outputs, one per column |
| east_o | output | N | Right edge application outputs, one per row |
| south_o | output | N | Bottom edge application outputs, one per column |

## Verification
Each configuration bit is held on the seed lanes for one cycle. The next bit follows eight cycles later, which is more than enough for a bit to cross one forwarding hop and for a full report to climb two levels. Every fullness check is therefore taken only after the following gap has elapsed. Each application value is one register behind its inputs and updates only on a step pulse. A value two cells deep in the array is therefore due after the second step, and the bench always issues two steps before sampling an edge output. It also samples on the falling clock edge, so the result of the last rising edge is already visible.

// File: rtl/reconf_tile.sv
module reconf_tile #(
  parameter int N = 4,
  parameter int SEED_ROW = 0,
  parameter logic [N*N-1:0] EMPTY_MASK = (N*N)'(1) | ((N*N)'(1) << N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         commit_i,
  input  logic         seed_clk_i,
  input  logic         seed_dat_i,
  output logic         seed_done_o,
  input  logic [N-1:0] west_i,
  input  logic [N-1:0] north_i,
  input  logic [N-1:0] east_i,
  input  logic [N-1:0] south_i,
  output logic [N-1:0] west_o,
  output logic [N-1:0] north_o,
  output logic [N-1:0] east_o,
  output logic [N-1:0] south_o
);
  localparam int CELLS = N*N;
  localparam logic [2:0] MD_ZERO = 3'b000, MD_ONE = 3'b001, MD_WIRE = 3'b010,
                         MD_MUX = 3'b011, MD_OPEN = 3'b100;

  logic [CELLS-1:0]   val;
  logic [4*CELLS-1:0] kout, dout;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int ID = r*N + c;
      localparam bit OPEN = EMPTY_MASK[ID];
      localparam logic [1:0] RPAR = (r == SEED_ROW && c == 0) ? 2'd0 :
                                    (r > SEED_ROW) ? 2'd1 : (r < SEED_ROW) ? 2'd3 : 2'd0;
      localparam logic [6:0] RBODY = OPEN ? {RPAR, 2'b00, MD_OPEN}
                                          : {2'd0, 2'b00, ((c % 2) == 1) ? MD_ONE : MD_ZERO};

      logic [3:0] ain, kin, din;
      logic [6:0] body, sh;
      logic [2:0] cnt;
      logic       pend, full_q, pclk_q, v_q, v_nxt;
      logic [3:0] fclk, fdat, open_c, pick;
      logic [1:0] par, o, o1, o2;
      logic       pk, pd, rise;

      if (c == 0) begin : g_wl
        assign ain[0] = west_i[r];
        assign kin[0] = (r == SEED_ROW) ? seed_clk_i : 1'b0;
        assign din[0] = (r == SEED_ROW) ? seed_dat_i : 1'b0;
      end else begin : g_wn
        assign ain[0] = val[ID-1];
        assign kin[0] = kout[4*(ID-1)+2];
        assign din[0] = dout[4*(ID-1)+2];
      end
      if (r == 0) begin : g_nl
        assign ain[1] = north_i[c];
        assign kin[1] = 1'b0;
        assign din[1] = 1'b0;
      end else begin : g_nn
        assign ain[1] = val[ID-N];
        assign kin[1] = kout[4*(ID-N)+3];
        assign din[1] = dout[4*(ID-N)+3];
      end
      if (c == N-1) begin : g_el
        assign ain[2] = east_i[r];
        assign kin[2] = 1'b0;
        assign din[2] = 1'b0;
      end else begin : g_en
        assign ain[2] = val[ID+1];
        assign kin[2] = kout[4*(ID+1)+0];
        assign din[2] = dout[4*(ID+1)+0];
      end
      if (r == N-1) begin : g_sl
        assign ain[3] = south_i[c];
        assign kin[3] = 1'b0;
        assign din[3] = 1'b0;
      end else begin : g_sn
        assign ain[3] = val[ID+N];
        assign kin[3] = kout[4*(ID+N)+1];
        assign din[3] = dout[4*(ID+N)+1];
      end

      assign par  = body[6:5];
      assign o    = body[4:3];
      assign o1   = o + 2'd1;
      assign o2   = o + 2'd2;
      assign pk   = kin[par];
      assign pd   = din[par];
      assign rise = pk & ~pclk_q;

      for (genvar s = 0; s < 4; s++) begin : g_side
        assign open_c[s] = (par != 2'(s)) & din[s] & ~kin[s];
        assign kout[4*ID+s] = (par == 2'(s)) ? full_q : fclk[s];
        assign dout[4*ID+s] = (par == 2'(s)) ? 1'b1   : fdat[s];
      end

      always_comb begin
        pick = 4'b0000;
        if      (open_c[0]) pick = 4'b0001;
        else if (open_c[1]) pick = 4'b0010;
        else if (open_c[2]) pick = 4'b0100;
        else if (open_c[3]) pick = 4'b1000;
      end

      always_comb begin
        case (body[2:0])
          MD_ONE:  v_nxt = 1'b1;
          MD_WIRE: v_nxt = ain[o];
          MD_MUX:  v_nxt = ain[o] ? ain[o2] : ain[o1];
          default: v_nxt = 1'b0;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          body   <= RBODY;
          sh     <= '0;
          cnt    <= OPEN ? 3'd0 : 3'd7;
          pend   <= 1'b0;
          full_q <= !OPEN;
          pclk_q <= 1'b0;
          fclk   <= '0;
          fdat   <= '0;
          v_q    <= 1'b0;
        end else begin
          pclk_q <= pk;
          fclk   <= '0;
          fdat   <= '0;
          if (rise) begin
            if (|open_c) begin
              fclk <= pick;
              fdat <= pick & {4{pd}};
            end else if (cnt != 3'd7) begin
              sh  <= {sh[5:0], pd};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd6) pend <= 1'b1;
            end
          end
          full_q <= (cnt == 3'd7) && !(|open_c);
          if (commit_i && pend) begin
            body <= sh;
            pend <= 1'b0;
          end
          if (step_i) v_q <= v_nxt;
        end
      end

      assign val[ID] = v_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign west_o[i]  = val[i*N];
    assign east_o[i]  = val[i*N + N-1];
    assign north_o[i] = val[i];
    assign south_o[i] = val[(N-1)*N + i];
  end

  assign seed_done_o = kout[4*(SEED_ROW*N)];
endmodule

// File: rtl/reconf_tile_chk.sv
module reconf_tile_chk #(
  parameter int N = 4,
  parameter logic [N*N-1:0] EMPTY_MASK = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_i,
  input logic         seed_clk_i,
  input logic         seed_done_o,
  input logic [N-1:0] west_o,
  input logic [N-1:0] north_o,
  input logic [N-1:0] east_o,
  input logic [N-1:0] south_o
);
  localparam int NEED = 7 * $countones(EMPTY_MASK);
  logic [15:0] rises;
  logic        prev_clk, seen_step;
  logic [4*N-1:0] outs;
  assign outs = {west_o, north_o, east_o, south_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0; prev_clk <= 1'b0; seen_step <= 1'b0;
    end else begin
      prev_clk <= seed_clk_i;
      if (seed_clk_i && !prev_clk && rises != 16'hFFFF) rises <= rises + 16'd1;
      if (step_i) seen_step <= 1'b1;
    end
  end

  AST_IDLE_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !seen_step |-> outs == '0); // R1
  AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n) !step_i |=> $stable(outs)); // R2
  AST_DONE_AFTER_BITS: assert property (@(posedge clk) disable iff (!rst_n) seed_done_o |-> rises >= 16'(NEED)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) seed_done_o |=> seed_done_o); // R4
endmodule

bind reconf_tile reconf_tile_chk #(.N(N), .EMPTY_MASK(EMPTY_MASK)) u_chk (.*);

// File: tb/reconf_tile_tb_top.sv
module reconf_tile_tb_top;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, step_i = 0, commit_i = 0, seed_clk_i = 0, seed_dat_i = 0;
  logic seed_done_o;
  logic [N-1:0] west_i = 0, north_i = 0, east_i = 0, south_i = 0;
  logic [N-1:0] west_o, north_o, east_o, south_o;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  reconf_tile #(.N(N)) dut_i (.*);

  localparam logic [6:0] B_MUX_L = 7'b01_00_011;
  localparam logic [6:0] B_WIRE  = 7'b00_00_010;
  localparam logic [6:0] B_MUX_B = 7'b01_11_011;

  // {a0 (west_i[0]), sel (west_i[1]), expected west_o[1] for MUX oriented left}
  localparam logic [2:0] VEC [4] = '{3'b000, 3'b101, 3'b011, 3'b111};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); seed_dat_i = b; seed_clk_i = 1;
    @(negedge clk); seed_clk_i = 0;
    repeat (7) @(negedge clk);
  endtask

  task automatic send_body(input logic [6:0] b);
    for (int i = 6; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic step2();
    repeat (2) begin
      @(negedge clk); step_i = 1;
      @(negedge clk); step_i = 0;
    end
  endtask

  task automatic commit();
    @(negedge clk); commit_i = 1;
    @(negedge clk); commit_i = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 outputs after reset", {west_o, north_o}, 8'h00);
    chk("R1 done after reset", {7'd0, seed_done_o}, 8'd0);

    send_body(B_MUX_L);
    chk("R4 not full with own bits missing", {7'd0, seed_done_o}, 8'd0);
    send_body(B_WIRE);
    chk("R4 full after all bits", {7'd0, seed_done_o}, 8'd1);

    west_i = 4'b0001;
    step2();
    chk("R5 open cells output 0 before commit", {6'd0, west_o[1:0]}, 8'd0);
    commit();
    step2();
    chk("R6 wire copies left", {7'd0, west_o[0]}, 8'd1);
    chk("R6 R9 guard constants east", {4'd0, east_o}, 8'h0F);
    chk("R6 R9 guard constants south", {4'd0, south_o}, 8'h0A);

    // R3 R7: postorder fill plus MUX select left, d0 top, d1 right
    foreach (VEC[i]) begin
      west_i[0] = VEC[i][2];
      west_i[1] = VEC[i][1];
      step2();
      chk("R3 R7 mux table", {7'd0, west_o[1]}, {7'd0, VEC[i][0]});
    end

    west_i = 4'b0001;
    step2();
    west_i = 4'b0010;
    repeat (6) @(negedge clk);
    chk("R2 no step no change", {6'd0, west_o[1:0]}, 8'b11);

    // R8: a second fill attempt is ignored
    send_body(B_MUX_B);
    send_body(B_WIRE);
    commit();
    west_i = 4'b0001;
    step2();
    chk("R8 refill ignored", {7'd0, west_o[1]}, 8'd1);
    chk("R4 done stays high", {7'd0, seed_done_o}, 8'd1);

    do_reset();
    chk("R1 outputs after second reset", {west_o, south_o}, 8'h00);
    send_body(B_MUX_B);
    send_body(B_WIRE);
    commit();
    for (int k = 0; k < 4; k++) begin
      west_i = 4'(k);
      step2();
      chk("R7 mux bottom select passes left", {7'd0, west_o[1]}, {7'd0, west_i[1]});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule